// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short run of instruction bytes ready for a decoder. It sits between a 16-bit code-fetch port and a consumer that takes one byte at a time. When enough slots are free and no operand transfer is waiting, it asks for the next sequential code address. A fetch at an even byte address returns two bytes in one transfer. A fetch at an odd address returns one byte, taken from the upper lane. The block keeps its own fetch pointer and advances it by the number of bytes it actually loaded.

A taken branch pulses the flush input together with the new code address. The queue empties, and fetching resumes at that address. If a bus transfer is already in flight, that transfer still finishes, but its data is discarded. An operand request is granted only while no code fetch is outstanding, so a fetch in progress always completes first. A two-bit registered status reports what happened to the queue in the previous cycle.

Top module: `prefetch_queue`

## Requirements
- R1: `count_o` equals the number of bytes held and never exceeds DEPTH (6). It is 0 after reset.
- R2: `fetch_req_o` rises only after a cycle in which all of the following held: no fetch was outstanding, at most DEPTH-2 bytes were held, `opnd_req_i` was low and `flush_i` was low. Once raised, it stays high with `fetch_addr_o` unchanged until the cycle in which `fetch_ack_i` is high. It is low after reset.
- R3: When a fetch whose address has bit 0 clear is accepted, two bytes are appended: first `fetch_data_i[7:0]`, then `fetch_data_i[15:8]`. The fetch pointer then advances by 2.
- R4: When a fetch whose address has bit 0 set is accepted, one byte, `fetch_data_i[15:8]`, is appended. The fetch pointer then advances by 1.
- R5: `byte_o` shows the oldest byte. `byte_valid_o` is high exactly when the queue is not empty. A high `byte_take_i` removes one byte. When the queue is empty, `byte_take_i` has no effect on count, data or status.
- R6: `opnd_gnt_o` is high exactly when `opnd_req_i` is high and no code fetch is outstanding.
- R7: In the cycle after `flush_i` is high, the queue is empty. The next fetch request uses `flush_addr_i` as its address.
- R8: A fetch acknowledged in the same cycle as a flush, or after a flush and before its own acknowledge, adds no bytes to the queue.
- R9: `status_o` is registered and describes the previous cycle: 2'b00 means no byte was taken; 2'b01 means a byte was taken with `first_i` high; 2'b10 means a byte was taken with `first_i` low; 2'b11 means a flush. Flush wins over the other codes.
- R10: A removal and an accepted fetch in the same cycle are both applied. The new count is the old count minus 1 plus the number of bytes loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Branch taken: empty the queue and reload |
| flush_addr_i | input | AW (20) | New code byte address used with flush_i |
| opnd_req_i | input | 1 | Operand transfer wants the bus |
| opnd_gnt_o | output | 1 | Operand transfer may use the bus |
| fetch_req_o | output | 1 | Code fetch request, held until acknowledged |
| fetch_addr_o | output | AW (20) | Byte address of the requested code fetch |
| fetch_ack_i | input | 1 | Fetch completes in this cycle |
| fetch_data_i | input | 16 | Fetched word; low lane is the even byte |
| byte_valid_o | output | 1 | A byte is available at the output end |
| byte_o | output | 8 | Oldest queued byte |
| byte_take_i | input | 1 | Consumer removes the output byte |
| first_i | input | 1 | Removed byte starts an instruction |
| count_o | output | CW (3) | Number of queued bytes |
| status_o | output | 2 | Queue operation in the previous cycle |

## Verification
The bench targets these corner cases:
- A flush that lands while a fetch is still in flight. A design that kept the late data would show bytes from the old path at the head of the queue.
- A flush to an odd address. A design that read the wrong lane or stepped the pointer by two would fetch or present the wrong bytes.
- A removal in the same cycle as an acknowledge. A design that got the write position wrong would drop or duplicate a byte.
- A full queue. A design that launched a fetch with fewer than two free slots would overflow.
- An empty queue with takes still driven. A design that let a take through would underflow or report a take in its status.
- An operand request raised during an outstanding fetch. A design that granted it early would break the ordering between code fetches and operand transfers.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH      = 6,
  parameter int AW         = 20,
  parameter int START_ADDR = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic [AW-1:0]                flush_addr_i,
  input  logic                         opnd_req_i,
  output logic                         opnd_gnt_o,
  output logic                         fetch_req_o,
  output logic [AW-1:0]                fetch_addr_o,
  input  logic                         fetch_ack_i,
  input  logic [15:0]                  fetch_data_i,
  output logic                         byte_valid_o,
  output logic [7:0]                   byte_o,
  input  logic                         byte_take_i,
  input  logic                         first_i,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic [1:0]                   status_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH-2);
  localparam logic [1:0] ST_IDLE = 2'b00, ST_FIRST = 2'b01, ST_NEXT = 2'b10, ST_FLUSH = 2'b11;

  logic [7:0]    q     [DEPTH];
  logic [7:0]    q_nxt [DEPTH];
  logic [CW-1:0] cnt, base;
  logic [AW-1:0] ptr, addr_q;
  logic          req, drop;
  logic [1:0]    sts;
  logic          take, acc, two, launch;
  logic [1:0]    nload;

  assign take   = byte_take_i && (cnt != '0) && !flush_i;
  assign acc    = req && fetch_ack_i && !drop && !flush_i;
  assign two    = !addr_q[0];
  assign nload  = acc ? (two ? 2'd2 : 2'd1) : 2'd0;
  assign base   = cnt - CW'(take);
  assign launch = !req && !flush_i && !opnd_req_i && (cnt <= ROOM_LIMIT);

  always_comb begin
    for (int i = 0; i < DEPTH-1; i++) q_nxt[i] = take ? q[i+1] : q[i];
    q_nxt[DEPTH-1] = q[DEPTH-1];
    if (acc) begin
      q_nxt[base] = two ? fetch_data_i[7:0] : fetch_data_i[15:8];
      if (two) q_nxt[CW'(base + CW'(1))] = fetch_data_i[15:8];
    end
  end

  always_ff @(posedge clk) q <= q_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      ptr    <= AW'(START_ADDR);
      addr_q <= AW'(START_ADDR);
      req    <= 1'b0;
      drop   <= 1'b0;
      sts    <= ST_IDLE;
    end else begin
      if (flush_i) begin
        cnt <= '0;
        ptr <= flush_addr_i;
        sts <= ST_FLUSH;
      end else begin
        cnt <= base + CW'(nload);
        ptr <= ptr + AW'(nload);
        sts <= take ? (first_i ? ST_FIRST : ST_NEXT) : ST_IDLE;
      end
      if (req && fetch_ack_i) begin
        req  <= 1'b0;
        drop <= 1'b0;
      end else begin
        if (flush_i && req) drop <= 1'b1;
        if (launch) begin
          req    <= 1'b1;
          addr_q <= ptr;
        end
      end
    end
  end

  assign opnd_gnt_o   = opnd_req_i && !req;
  assign fetch_req_o  = req;
  assign fetch_addr_o = addr_q;
  assign byte_valid_o = (cnt != '0);
  assign byte_o       = q[0];
  assign count_o      = cnt;
  assign status_o     = sts;

  assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_launch_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(cnt) <= ROOM_LIMIT) && !$past(opnd_req_i) && !$past(flush_i));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req && !fetch_ack_i |=> req && $stable(fetch_addr_o));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt == '0) && (status_o == ST_FLUSH));

  assert_drop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (cnt == '0) && !byte_valid_o);

  assert_both_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req && fetch_ack_i && !drop && !flush_i && byte_take_i && (cnt != '0)
    |=> cnt == $past(cnt) + (($past(addr_q[0])) ? CW'(0) : CW'(1)));
endmodule

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0, opnd = 1'b0, take = 1'b0, first = 1'b0;
  logic [AW-1:0] faddr = '0;
  logic          auto_ack = 1'b0, auto_ack_r = 1'b0, man_ack = 1'b0;
  logic          ack;
  logic [15:0]   data;
  logic          opnd_gnt_o, fetch_req_o, byte_valid_o;
  logic [AW-1:0] fetch_addr_o;
  logic [7:0]    byte_o;
  logic [2:0]    count_o;
  logic [1:0]    status_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int unsigned seed_a = 32'h1234_5678, seed_b = 32'h9E37_79B9;

  logic [7:0] mq[$];
  int  m_ptr = 0, m_addr = 0;
  bit  m_req = 0, m_drop = 0;
  int  m_sts = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_at(input int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction

  function automatic int unsigned xs(input int unsigned s);
    int unsigned t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  assign ack  = auto_ack ? auto_ack_r : man_ack;
  assign data = {mem_at(int'(fetch_addr_o | 20'h1)), mem_at(int'(fetch_addr_o & ~20'h1))};

  prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .flush_addr_i(faddr),
    .opnd_req_i(opnd), .opnd_gnt_o(opnd_gnt_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .fetch_ack_i(ack), .fetch_data_i(data),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .byte_take_i(take),
    .first_i(first), .count_o(count_o), .status_o(status_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_req();
    for (int k = 0; k < 20 && !fetch_req_o; k++) step();
  endtask

  always @(posedge clk) begin
    #1;
    seed_b = xs(seed_b);
    auto_ack_r = fetch_req_o && (seed_b % 3 == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_ptr = 0; m_addr = 0; m_req = 0; m_drop = 0; m_sts = 0;
    end else begin
      bit tk, ak, ln;
      ak = m_req && ack;
      ln = !m_req && !flush && !opnd && (mq.size() <= 4);
      tk = take && (mq.size() > 0) && !flush;
      if (flush) begin
        mq.delete();
        m_ptr = int'(faddr);
        m_sts = 3;
        if (m_req && !ak) m_drop = 1;
      end else begin
        if (tk) begin
          void'(mq.pop_front());
          m_sts = first ? 1 : 2;
        end else m_sts = 0;
        if (ak && !m_drop) begin
          if (m_addr % 2 == 1) begin
            mq.push_back(data[15:8]);
            m_ptr = (m_ptr + 1) & 32'hFFFFF;
          end else begin
            mq.push_back(data[7:0]);
            mq.push_back(data[15:8]);
            m_ptr = (m_ptr + 2) & 32'hFFFFF;
          end
        end
      end
      if (ak) begin
        m_req = 0; m_drop = 0;
      end else if (ln) begin
        m_req = 1; m_addr = m_ptr;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(count_o) == mq.size(), "R1 count", int'(count_o), mq.size());
      chk(fetch_req_o == m_req, "R2 fetch_req", int'(fetch_req_o), int'(m_req));
      if (m_req) chk(int'(fetch_addr_o) == m_addr, "R3 fetch_addr", int'(fetch_addr_o), m_addr);
      chk(byte_valid_o == (mq.size() > 0), "R5 valid", int'(byte_valid_o), int'(mq.size() > 0));
      if (mq.size() > 0) chk(byte_o == mq[0], "R5 head byte", int'(byte_o), int'(mq[0]));
      chk(int'(status_o) == m_sts, "R9 status", int'(status_o), m_sts);
      chk(opnd_gnt_o == (opnd && !m_req), "R6 grant", int'(opnd_gnt_o), int'(opnd && !m_req));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_o == 3'd0, "R1 reset count", int'(count_o), 0);
    chk(!byte_valid_o, "R5 reset valid", int'(byte_valid_o), 0);
    chk(status_o == 2'b00, "R9 reset status", int'(status_o), 0);
    chk(!fetch_req_o, "R2 reset req", int'(fetch_req_o), 0);

    // R8: flush while a fetch is outstanding, then the late ack is dropped
    step(); flush = 1; faddr = 20'h100;
    step(); flush = 0;
    wait_req();
    flush = 1; faddr = 20'h203;
    step(); flush = 0; man_ack = 1;
    step(); man_ack = 0;
    @(negedge clk);
    chk(count_o == 3'd0, "R8 dropped fetch", int'(count_o), 0);
    step();
    @(negedge clk);
    chk(fetch_req_o && fetch_addr_o == 20'h203, "R7 restart addr", int'(fetch_addr_o), 'h203);
    step(); man_ack = 1;
    step(); man_ack = 0;
    @(negedge clk);
    chk(count_o == 3'd1, "R4 odd count", int'(count_o), 1);
    chk(byte_o == mem_at('h203), "R4 odd lane", int'(byte_o), int'(mem_at('h203)));
    step(); wait_req();
    @(negedge clk);
    chk(fetch_addr_o == 20'h204, "R4 pointer plus one", int'(fetch_addr_o), 'h204);
    step(); man_ack = 1;
    step(); man_ack = 0;
    @(negedge clk);
    chk(count_o == 3'd3, "R3 even count", int'(count_o), 3);
    step(); wait_req();
    take = 1; first = 1; man_ack = 1;
    step(); take = 0; first = 0; man_ack = 0;
    @(negedge clk);
    chk(count_o == 3'd4, "R10 both ops", int'(count_o), 4);
    chk(byte_o == mem_at('h204), "R10 head after take", int'(byte_o), int'(mem_at('h204)));
    chk(status_o == 2'b01, "R9 first taken", int'(status_o), 1);

    // R6: operand request while a fetch is outstanding
    step(); wait_req();
    opnd = 1;
    step();
    @(negedge clk);
    chk(!opnd_gnt_o, "R6 no grant during fetch", int'(opnd_gnt_o), 0);
    step(); man_ack = 1;
    step(); man_ack = 0;
    @(negedge clk);
    chk(opnd_gnt_o, "R6 grant after fetch", int'(opnd_gnt_o), 1);
    chk(count_o == 3'd6, "R1 full", int'(count_o), 6);
    step(); opnd = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      @(negedge clk);
      chk(!fetch_req_o, "R2 no fetch when full", int'(fetch_req_o), 0);
    end

    // R5: drain to empty, then takes are ignored
    step(); opnd = 1; take = 1;
    repeat (9) step();
    @(negedge clk);
    chk(count_o == 3'd0 && !byte_valid_o, "R5 empty stall", int'(count_o), 0);
    chk(status_o == 2'b00, "R5 take ignored when empty", int'(status_o), 0);
    step(); opnd = 0; take = 0;

    // mixed traffic against the reference model
    auto_ack = 1;
    for (int n = 0; n < 6000; n++) begin
      step();
      seed_a = xs(seed_a);
      take  = (seed_a % 3) != 0;
      first = ((seed_a >> 4) % 4) == 0;
      opnd  = ((seed_a >> 8) % 10) == 0;
      flush = ((seed_a >> 12) % 40) == 0;
      faddr = AW'(seed_a >> 7);
    end
    step(); take = 0; opnd = 0; flush = 0;
    repeat (4) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule